// File: doc/BRIEF.md
# CAN Acceptance Filter and Message-Object Matcher

This block sits between a CAN receive engine and the host. For each incoming frame it takes the identifier, the format flag (standard 11-bit or extended 29-bit) and the frame kind (data or remote). It then picks one of two global don't-care masks by format and compares the masked identifier against a table of message objects. The first valid object that agrees wins. The block reports that object's index, or flags the frame as rejected if no object agrees.

Each object has a direction. A data frame that lands on a receive object marks that object's receive status and receive flag. A remote frame that lands on a transmit object makes the block ask the transmit engine, on its own, for that object's data frame. The host programs the masks and the objects through a simple write port. It can also trigger an object by index: a receive object then sends a remote frame, and a transmit object sends its data frame. Every request carries the object's identifier, format and data length. Status and flag bits are cleared by writing ones to them. A single interrupt line summarises the flags that the host has enabled.

Top module: `can_acceptance_filter`

## Requirements
- R1: After reset both masks are zero, every object is invalid, all status and flag vectors are zero and every output is low. A frame sent before any object is configured is rejected.
- R2: A standard frame (frmExt=0) is compared only on identifier bits [10:0], using the 11-bit standard mask at host address 0. A mask bit of 1 makes that identifier bit don't-care. Identifier bits above bit 10 of a standard frame are ignored.
- R3: An extended frame (frmExt=1) is compared on all 29 identifier bits, using the separate extended mask at host address 1.
- R4: An object matches only when all three hold: its valid bit (word A bit 31) is set, its format bit (word A bit 29) equals frmExt, and the masked identifiers agree. A frame drives exactly one of hitValid or rejValid high, for one cycle, on the cycle after frmValid.
- R5: When several objects match, hitIdx reports the lowest-numbered one.
- R6: A data frame (frmRemote=0) that wins on a receive object (word A bit 30 = 0) sets that object's bit in rxStatus and in rxFlag. A remote frame that wins on a receive object only reports the hit.
- R7: A remote frame that wins on a transmit object (word A bit 30 = 1) raises txReqValid on the next cycle. The request carries that object's index, identifier, format and length, with txReqRemote=0, and it sets the object's txStatus and txFlag bits. A data frame that wins on a transmit object only reports the hit.
- R8: A host write to address 6 with an index in data bits [3:0] triggers that object. A valid receive object produces a request with txReqRemote=1. A valid transmit object produces a request with txReqRemote=0. An invalid object, or an index of 15 or more, produces no request.
- R9: When an automatic reply and a host trigger fall in the same cycle, the automatic reply is issued and the trigger is discarded.
- R10: Writing ones clears bits: address 2 clears rxStatus, 3 clears txStatus, 4 clears rxFlag and 5 clears txFlag, with data bit k for object k. A set and a clear of the same bit in the same cycle leave the bit set.
- R11: irq is high exactly when some object has its rxFlag set together with its receive interrupt enable (word B bit 4), or its txFlag set together with its transmit interrupt enable (word B bit 5).
- R12: The length written in word B bits [3:0] is stored clamped to 1..8: a value of 0 becomes 1 and a value above 8 becomes 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 6 | Host register address; object k uses word A at 8+2k and word B at 9+2k |
| hostWrData | input | 32 | Host write data; word A = {valid, dir, ext, id[28:0]}, word B = {txIe, rxIe, len[3:0]} in the low bits |
| frmValid | input | 1 | Incoming frame header present this cycle |
| frmId | input | 29 | Incoming identifier (standard frames use bits [10:0]) |
| frmExt | input | 1 | Incoming frame is extended format |
| frmRemote | input | 1 | Incoming frame is a remote frame |
| hitValid | output | 1 | Frame matched an object (one cycle) |
| hitIdx | output | 4 | Index of the winning object |
| rejValid | output | 1 | Frame matched no object (one cycle) |
| txReqValid | output | 1 | Transmit request (one cycle) |
| txReqIdx | output | 4 | Object index of the request |
| txReqId | output | 29 | Identifier to transmit |
| txReqExt | output | 1 | Format of the requested frame |
| txReqRemote | output | 1 | Requested frame is a remote frame |
| txReqDlc | output | 4 | Data length of the requested frame (1..8) |
| rxStatus | output | 15 | Per-object receive status |
| txStatus | output | 15 | Per-object transmit status |
| rxFlag | output | 15 | Per-object receive interrupt flag |
| txFlag | output | 15 | Per-object transmit interrupt flag |
| irq | output | 1 | OR of enabled flags |

## Verification
The bench builds the block with the default table of 15 objects. With that size, object 14 is the highest usable index, and a trigger with index 15 is just past the table. Both edges are exercised, along with an unconfigured object 0 that sits below overlapping valid objects 1 and 2. The masks are set so that the two overlapping standard objects both accept some frames, which tests the lowest-index rule. One extended object shares low identifier bits with standard frames, which shows that format, and not identifier alone, decides a match.

// File: rtl/canfilt_pkg.sv
package canfilt_pkg;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned STD_W  = 11;
  localparam int unsigned EXT_W  = 29;
  localparam int unsigned DLC_W  = 4;
  localparam int unsigned HOST_W = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic             setRx;
    logic [IDX_W-1:0] rxIdx;
    logic             reqLoad;
    logic [IDX_W-1:0] reqIdx;
    logic             reqRemote;
  } strobe_t;
endpackage

// File: rtl/canfilt_datapath.sv
module canfilt_datapath
  import canfilt_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 15,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [HOST_W-1:0]  hostWrData,
  input  logic [EXT_W-1:0]   frmId,
  input  logic               frmExt,
  input  strobe_t            strobe,
  output logic [NUM_OBJ-1:0] hitVec,
  output logic [NUM_OBJ-1:0] objDirVec,
  output logic               trigValid,
  output logic [IDX_W-1:0]   trigIdx,
  output logic               trigRemote,
  output logic               txReqValid,
  output logic [IDX_W-1:0]   txReqIdx,
  output logic [EXT_W-1:0]   txReqId,
  output logic               txReqExt,
  output logic               txReqRemote,
  output logic [DLC_W-1:0]   txReqDlc,
  output logic [NUM_OBJ-1:0] rxStatus,
  output logic [NUM_OBJ-1:0] txStatus,
  output logic [NUM_OBJ-1:0] rxFlag,
  output logic [NUM_OBJ-1:0] txFlag,
  output logic               irq
);
  localparam int unsigned OBJ_BASE = 8;
  localparam logic [ADDR_W-1:0] A_STD   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EXT   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLRRS = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLRTS = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLRRF = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CLRTF = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(6);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_OBJ - 1);
  localparam logic [DLC_W-1:0]  DLC_MAX  = DLC_W'(8);

  function automatic logic [DLC_W-1:0] clampDlc(input logic [DLC_W-1:0] d);
    if (d == '0)     return DLC_W'(1);
    if (d > DLC_MAX) return DLC_MAX;
    return d;
  endfunction

  logic [STD_W-1:0]   stdMask;
  logic [EXT_W-1:0]   extMask;
  logic [EXT_W-1:0]   objId  [NUM_OBJ];
  logic [DLC_W-1:0]   objDlc [NUM_OBJ];
  logic [NUM_OBJ-1:0] objExt, objValid, objRxIe, objTxIe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stdMask <= '0;
      extMask <= '0;
    end else if (hostWrEn) begin
      if (hostAddr == A_STD) stdMask <= hostWrData[STD_W-1:0];
      if (hostAddr == A_EXT) extMask <= hostWrData[EXT_W-1:0];
    end
  end

  // per-object storage and comparator
  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    localparam logic [ADDR_W-1:0] A_WA = ADDR_W'(OBJ_BASE + 2*g);
    localparam logic [ADDR_W-1:0] A_WB = ADDR_W'(OBJ_BASE + 2*g + 1);
    logic [EXT_W-1:0] idR;
    logic [DLC_W-1:0] dlcR;
    logic             extR, dirR, valR, rxIeR, txIeR;
    logic [EXT_W-1:0] diff;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idR <= '0; extR <= 1'b0; dirR <= 1'b0; valR <= 1'b0;
        dlcR <= DLC_W'(1); rxIeR <= 1'b0; txIeR <= 1'b0;
      end else if (hostWrEn) begin
        if (hostAddr == A_WA) begin
          idR  <= hostWrData[EXT_W-1:0];
          extR <= hostWrData[EXT_W];
          dirR <= hostWrData[EXT_W+1];
          valR <= hostWrData[EXT_W+2];
        end
        if (hostAddr == A_WB) begin
          dlcR  <= clampDlc(hostWrData[DLC_W-1:0]);
          rxIeR <= hostWrData[DLC_W];
          txIeR <= hostWrData[DLC_W+1];
        end
      end
    end

    assign diff = frmId ^ idR;
    assign hitVec[g] = valR && (extR == frmExt) &&
                       (frmExt ? ((diff & ~extMask) == '0)
                               : ((diff[STD_W-1:0] & ~stdMask) == '0));
    assign objId[g]     = idR;
    assign objDlc[g]    = dlcR;
    assign objExt[g]    = extR;
    assign objDirVec[g] = dirR;
    assign objValid[g]  = valR;
    assign objRxIe[g]   = rxIeR;
    assign objTxIe[g]   = txIeR;
  end

  // host trigger decode
  assign trigIdx    = hostWrData[IDX_W-1:0];
  assign trigValid  = hostWrEn && (hostAddr == A_TRIG) && (trigIdx <= LAST_IDX) && objValid[trigIdx];
  assign trigRemote = !objDirVec[trigIdx];

  // status set and clear
  logic [NUM_OBJ-1:0] setRxVec, setTxVec;
  logic [NUM_OBJ-1:0] clrRs, clrTs, clrRf, clrTf;
  always_comb begin
    for (int k = 0; k < int'(NUM_OBJ); k++) begin
      setRxVec[k] = strobe.setRx   && (strobe.rxIdx  == IDX_W'(k));
      setTxVec[k] = strobe.reqLoad && (strobe.reqIdx == IDX_W'(k));
    end
    clrRs = (hostWrEn && hostAddr == A_CLRRS) ? hostWrData[NUM_OBJ-1:0] : '0;
    clrTs = (hostWrEn && hostAddr == A_CLRTS) ? hostWrData[NUM_OBJ-1:0] : '0;
    clrRf = (hostWrEn && hostAddr == A_CLRRF) ? hostWrData[NUM_OBJ-1:0] : '0;
    clrTf = (hostWrEn && hostAddr == A_CLRTF) ? hostWrData[NUM_OBJ-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxStatus <= '0; txStatus <= '0; rxFlag <= '0; txFlag <= '0;
    end else begin
      rxStatus <= (rxStatus & ~clrRs) | setRxVec;
      txStatus <= (txStatus & ~clrTs) | setTxVec;
      rxFlag   <= (rxFlag   & ~clrRf) | setRxVec;
      txFlag   <= (txFlag   & ~clrTf) | setTxVec;
    end
  end

  // transmit request register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReqValid <= 1'b0; txReqIdx <= '0; txReqId <= '0;
      txReqExt <= 1'b0; txReqRemote <= 1'b0; txReqDlc <= '0;
    end else begin
      txReqValid <= strobe.reqLoad;
      if (strobe.reqLoad) begin
        txReqIdx    <= strobe.reqIdx;
        txReqId     <= objId[strobe.reqIdx];
        txReqExt    <= objExt[strobe.reqIdx];
        txReqRemote <= strobe.reqRemote;
        txReqDlc    <= objDlc[strobe.reqIdx];
      end
    end
  end

  assign irq = |((rxFlag & objRxIe) | (txFlag & objTxIe));
endmodule

// File: rtl/canfilt_control.sv
module canfilt_control
  import canfilt_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frmValid,
  input  logic               frmRemote,
  input  logic [NUM_OBJ-1:0] hitVec,
  input  logic [NUM_OBJ-1:0] objDirVec,
  input  logic               trigValid,
  input  logic [IDX_W-1:0]   trigIdx,
  input  logic               trigRemote,
  output strobe_t            strobe,
  output logic               hitValid,
  output logic [IDX_W-1:0]   hitIdx,
  output logic               rejValid
);
  logic [IDX_W-1:0] winIdx;
  logic             anyHit, accept, autoReply, winDir;

  // lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = int'(NUM_OBJ) - 1; i >= 0; i--) begin
      if (hitVec[i]) winIdx = IDX_W'(i);
    end
  end

  assign anyHit    = |hitVec;
  assign winDir    = objDirVec[winIdx];
  assign accept    = frmValid && anyHit;
  assign autoReply = accept && frmRemote && winDir;

  always_comb begin
    strobe.setRx     = accept && !frmRemote && !winDir;
    strobe.rxIdx     = winIdx;
    strobe.reqLoad   = autoReply || trigValid;
    strobe.reqIdx    = autoReply ? winIdx : trigIdx;
    strobe.reqRemote = autoReply ? 1'b0 : trigRemote;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid <= 1'b0;
      hitIdx   <= '0;
      rejValid <= 1'b0;
    end else begin
      hitValid <= accept;
      hitIdx   <= accept ? winIdx : '0;
      rejValid <= frmValid && !anyHit;
    end
  end
endmodule

// File: rtl/can_acceptance_filter.sv
module can_acceptance_filter
  import canfilt_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 15,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [HOST_W-1:0]  hostWrData,
  input  logic               frmValid,
  input  logic [EXT_W-1:0]   frmId,
  input  logic               frmExt,
  input  logic               frmRemote,
  output logic               hitValid,
  output logic [IDX_W-1:0]   hitIdx,
  output logic               rejValid,
  output logic               txReqValid,
  output logic [IDX_W-1:0]   txReqIdx,
  output logic [EXT_W-1:0]   txReqId,
  output logic               txReqExt,
  output logic               txReqRemote,
  output logic [DLC_W-1:0]   txReqDlc,
  output logic [NUM_OBJ-1:0] rxStatus,
  output logic [NUM_OBJ-1:0] txStatus,
  output logic [NUM_OBJ-1:0] rxFlag,
  output logic [NUM_OBJ-1:0] txFlag,
  output logic               irq
);
  strobe_t            strobe;
  logic [NUM_OBJ-1:0] hitVec, objDirVec;
  logic               trigValid, trigRemote;
  logic [IDX_W-1:0]   trigIdx;

  canfilt_datapath #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .frmId(frmId), .frmExt(frmExt), .strobe(strobe),
    .hitVec(hitVec), .objDirVec(objDirVec),
    .trigValid(trigValid), .trigIdx(trigIdx), .trigRemote(trigRemote),
    .txReqValid(txReqValid), .txReqIdx(txReqIdx), .txReqId(txReqId),
    .txReqExt(txReqExt), .txReqRemote(txReqRemote), .txReqDlc(txReqDlc),
    .rxStatus(rxStatus), .txStatus(txStatus), .rxFlag(rxFlag), .txFlag(txFlag),
    .irq(irq)
  );

  canfilt_control #(.NUM_OBJ(NUM_OBJ)) u_ctl (
    .clk(clk), .rstN(rstN),
    .frmValid(frmValid), .frmRemote(frmRemote),
    .hitVec(hitVec), .objDirVec(objDirVec),
    .trigValid(trigValid), .trigIdx(trigIdx), .trigRemote(trigRemote),
    .strobe(strobe),
    .hitValid(hitValid), .hitIdx(hitIdx), .rejValid(rejValid)
  );
endmodule

// File: rtl/can_acceptance_filter_checker.sv
module can_acceptance_filter_checker
  import canfilt_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 15
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostWrEn,
  input logic               frmValid,
  input logic               hitValid,
  input logic [IDX_W-1:0]   hitIdx,
  input logic               rejValid,
  input logic               txReqValid,
  input logic [IDX_W-1:0]   txReqIdx,
  input logic [DLC_W-1:0]   txReqDlc,
  input logic [NUM_OBJ-1:0] txStatus,
  input logic [NUM_OBJ-1:0] rxFlag,
  input logic [NUM_OBJ-1:0] txFlag,
  input logic               irq
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OBJ - 1);

  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(frmValid)) |-> (hitValid ^ rejValid));

  p_quiet_without_frame_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(frmValid)) |-> (!hitValid && !rejValid));

  p_hit_index_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (hitIdx <= LAST_IDX));

  p_request_marks_status_r7: assert property (@(posedge clk) disable iff (!rstN)
    txReqValid |-> txStatus[txReqIdx]);

  p_request_length_r12: assert property (@(posedge clk) disable iff (!rstN)
    txReqValid |-> (txReqDlc >= 4'd1 && txReqDlc <= 4'd8));

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(hostWrEn)) |->
      (((rxFlag & $past(rxFlag)) == $past(rxFlag)) && ((txFlag & $past(txFlag)) == $past(txFlag))));

  p_irq_has_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|(rxFlag | txFlag)));
endmodule

bind can_acceptance_filter can_acceptance_filter_checker #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .frmValid(frmValid),
  .hitValid(hitValid), .hitIdx(hitIdx), .rejValid(rejValid),
  .txReqValid(txReqValid), .txReqIdx(txReqIdx), .txReqDlc(txReqDlc),
  .txStatus(txStatus), .rxFlag(rxFlag), .txFlag(txFlag), .irq(irq)
);

// File: tb/can_acceptance_filter_bench.sv
`timescale 1ns/1ps
module can_acceptance_filter_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        hostWrEn;
  logic [5:0]  hostAddr;
  logic [31:0] hostWrData;
  logic        frmValid, frmExt, frmRemote;
  logic [28:0] frmId;
  logic        hitValid, rejValid, txReqValid, txReqExt, txReqRemote, irq;
  logic [3:0]  hitIdx, txReqIdx, txReqDlc;
  logic [28:0] txReqId;
  logic [14:0] rxStatus, txStatus, rxFlag, txFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  can_acceptance_filter u_can_acceptance_filter (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .frmValid(frmValid), .frmId(frmId), .frmExt(frmExt), .frmRemote(frmRemote),
    .hitValid(hitValid), .hitIdx(hitIdx), .rejValid(rejValid),
    .txReqValid(txReqValid), .txReqIdx(txReqIdx), .txReqId(txReqId), .txReqExt(txReqExt),
    .txReqRemote(txReqRemote), .txReqDlc(txReqDlc),
    .rxStatus(rxStatus), .txStatus(txStatus), .rxFlag(rxFlag), .txFlag(txFlag), .irq(irq)
  );

  // {remote, ext, id[28:0], expHit, expIdx[3:0], expReq, expReqId[28:0], expDlc[3:0]}
  localparam logic [69:0] VEC [11] = '{
    {1'b0, 1'b0, 29'h100,      1'b0, 4'd0,  1'b0, 29'h0,        4'd0},  // invalid obj0 only
    {1'b0, 1'b0, 29'h12A,      1'b1, 4'd1,  1'b0, 29'h0,        4'd0},  // obj1 beats obj2
    {1'b0, 1'b0, 29'h1FFFF125, 1'b1, 4'd1,  1'b0, 29'h0,        4'd0},  // upper bits ignored
    {1'b0, 1'b0, 29'h13A,      1'b0, 4'd0,  1'b0, 29'h0,        4'd0},  // unmasked bit differs
    {1'b1, 1'b0, 29'h7F3,      1'b1, 4'd14, 1'b1, 29'h7F0,      4'd5},  // auto reply obj14
    {1'b1, 1'b1, 29'h1ABCD0FF, 1'b1, 4'd3,  1'b1, 29'h1ABCD000, 4'd8},  // auto reply obj3
    {1'b0, 1'b1, 29'h1ABCD1FF, 1'b0, 4'd0,  1'b0, 29'h0,        4'd0},  // ext bit 8 differs
    {1'b0, 1'b0, 29'h355,      1'b0, 4'd0,  1'b0, 29'h0,        4'd0},  // format mismatch
    {1'b0, 1'b1, 29'h3AA,      1'b1, 4'd4,  1'b0, 29'h0,        4'd0},  // ext mask hit obj4
    {1'b1, 1'b0, 29'h125,      1'b1, 4'd1,  1'b0, 29'h0,        4'd0},  // remote on rx obj
    {1'b0, 1'b0, 29'h7F0,      1'b1, 4'd14, 1'b0, 29'h0,        4'd0}   // data on tx obj
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic sendFrame(input logic r, input logic e, input logic [28:0] id);
    @(negedge clk);
    frmValid = 1'b1; frmRemote = r; frmExt = e; frmId = id;
    @(negedge clk);
    frmValid = 1'b0;
  endtask

  task automatic setObj(input int k, input logic [31:0] wa, input logic [31:0] wb);
    hostWrite(6'(8 + 2*k), wa);
    hostWrite(6'(9 + 2*k), wb);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; hostWrEn = 1'b0; hostAddr = '0; hostWrData = '0;
    frmValid = 1'b0; frmExt = 1'b0; frmRemote = 1'b0; frmId = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 hitValid", 32'(hitValid), 0);
    chk("R1 rejValid", 32'(rejValid), 0);
    chk("R1 txReqValid", 32'(txReqValid), 0);
    chk("R1 rxStatus", 32'(rxStatus), 0);
    chk("R1 txStatus", 32'(txStatus), 0);
    chk("R1 irq", 32'(irq), 0);
    sendFrame(1'b0, 1'b0, 29'h0);
    chk("R1 unconfigured reject", 32'(rejValid), 1);
    chk("R1 unconfigured no hit", 32'(hitValid), 0);

    // configuration: masks and objects (word A = {valid,dir,ext,id})
    hostWrite(6'd0, 32'h0000_000F);
    hostWrite(6'd1, 32'h0000_00FF);
    setObj(0,  {1'b0, 1'b0, 1'b0, 29'h100},      32'h03);
    setObj(1,  {1'b1, 1'b0, 1'b0, 29'h120},      32'h12);  // rxIe, len 2
    setObj(2,  {1'b1, 1'b1, 1'b0, 29'h12A},      32'h00);  // len 0 -> 1
    setObj(3,  {1'b1, 1'b1, 1'b1, 29'h1ABCD000}, 32'h2C);  // txIe, len 12 -> 8
    setObj(4,  {1'b1, 1'b0, 1'b1, 29'h355},      32'h04);
    setObj(14, {1'b1, 1'b1, 1'b0, 29'h7F0},      32'h05);

    // vector walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 11; v++) begin
      logic [69:0] e;
      e = VEC[v];
      sendFrame(e[69], e[68], e[67:39]);
      chk($sformatf("R4 vec%0d hitValid", v), 32'(hitValid), 32'(e[38]));
      chk($sformatf("R4 vec%0d rejValid", v), 32'(rejValid), 32'(!e[38]));
      if (e[38]) chk($sformatf("R5 vec%0d hitIdx", v), 32'(hitIdx), 32'(e[37:34]));
      chk($sformatf("R7 vec%0d txReqValid", v), 32'(txReqValid), 32'(e[33]));
      if (e[33]) begin
        chk($sformatf("R7 vec%0d txReqIdx", v), 32'(txReqIdx), 32'(e[37:34]));
        chk($sformatf("R7 vec%0d txReqId", v), 32'(txReqId), 32'(e[32:4]));
        chk($sformatf("R7 vec%0d txReqRemote", v), 32'(txReqRemote), 0);
        chk($sformatf("R7 vec%0d txReqExt", v), 32'(txReqExt), 32'(e[68]));
        chk($sformatf("R12 vec%0d txReqDlc", v), 32'(txReqDlc), 32'(e[3:0]));
      end
    end

    // R6 R7 accumulated status and flags
    chk("R6 rxStatus", 32'(rxStatus), 32'h0012);
    chk("R6 rxFlag", 32'(rxFlag), 32'h0012);
    chk("R7 txStatus", 32'(txStatus), 32'h4008);
    chk("R7 txFlag", 32'(txFlag), 32'h4008);
    chk("R11 irq from obj1 rx", 32'(irq), 1);

    // R10 R11 write-one-to-clear
    hostWrite(6'd4, 32'h0000_0002);
    chk("R10 rxFlag after clear", 32'(rxFlag), 32'h0010);
    chk("R10 rxStatus untouched", 32'(rxStatus), 32'h0012);
    chk("R11 irq from obj3 tx", 32'(irq), 1);
    hostWrite(6'd5, 32'h0000_7FFF);
    chk("R10 txFlag cleared", 32'(txFlag), 0);
    chk("R10 txStatus untouched", 32'(txStatus), 32'h4008);
    chk("R11 irq low, obj4 flag not enabled", 32'(irq), 0);

    // R10 set wins over clear in same cycle
    @(negedge clk);
    frmValid = 1'b1; frmRemote = 1'b0; frmExt = 1'b0; frmId = 29'h120;
    hostWrEn = 1'b1; hostAddr = 6'd2; hostWrData = 32'h0000_0002;
    @(negedge clk);
    frmValid = 1'b0; hostWrEn = 1'b0;
    chk("R10 set wins over clear", 32'(rxStatus), 32'h0012);
    chk("R11 irq back with rxFlag", 32'(irq), 1);
    hostWrite(6'd2, 32'h0000_7FFF);
    chk("R10 rxStatus cleared", 32'(rxStatus), 0);

    // R8 host trigger
    hostWrite(6'd6, 32'd1);
    chk("R8 trig rx valid", 32'(txReqValid), 1);
    chk("R8 trig rx idx", 32'(txReqIdx), 1);
    chk("R8 trig rx remote", 32'(txReqRemote), 1);
    chk("R8 trig rx id", 32'(txReqId), 32'h120);
    chk("R8 trig rx dlc", 32'(txReqDlc), 2);
    hostWrite(6'd6, 32'd2);
    chk("R8 trig tx valid", 32'(txReqValid), 1);
    chk("R8 trig tx remote", 32'(txReqRemote), 0);
    chk("R12 clamp zero to one", 32'(txReqDlc), 1);
    hostWrite(6'd6, 32'd0);
    chk("R8 trig invalid object ignored", 32'(txReqValid), 0);
    hostWrite(6'd6, 32'd15);
    chk("R8 trig out of range ignored", 32'(txReqValid), 0);

    // R9 auto reply beats trigger
    @(negedge clk);
    frmValid = 1'b1; frmRemote = 1'b1; frmExt = 1'b0; frmId = 29'h7F3;
    hostWrEn = 1'b1; hostAddr = 6'd6; hostWrData = 32'd1;
    @(negedge clk);
    frmValid = 1'b0; hostWrEn = 1'b0;
    chk("R9 reply issued", 32'(txReqValid), 1);
    chk("R9 reply idx", 32'(txReqIdx), 14);
    chk("R9 reply is data", 32'(txReqRemote), 0);
    @(negedge clk);
    chk("R9 trigger discarded", 32'(txReqValid), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule